// File: doc/BRIEF.md
# Data-Strobe Serial Receive Deserializer

This block turns a received data-strobe line pair back into parallel words for a link-layer controller. On the receive side the data bit travels on the first line pair and the strobe on the second, which is the reverse of the transmit pairing. The block samples both lines on its single system clock, passes them through a synchronizer, and watches the exclusive-OR of the two synchronized lines. Every change of that XOR marks one new bit, and the bit's value is the level of the data line at that moment. No recovered clock domain is needed.

The bits are gathered into 4-bit words in the 200 Mb/s class (`spd_hi` = 1) or 2-bit words in the 100 Mb/s class (`spd_hi` = 0). Each completed word is presented with a one-cycle valid strobe. An alignment flag shows whether a partial word is held. While receive is enabled, the block tells the port's own line drivers to stay off. Dropping the receive enable discards any partial word, so the next packet starts on a word boundary.

Top module: `ds_rx_deser`

## Requirements
- R1: After reset `word_o` is 4'b0000, `word_vld_o` is 0 and `aligned_o` is 1.
- R2: Each change of `line_a` XOR `line_b` adds exactly one bit while `rx_en` is 1, and the bit's value is the level of `line_a` (the data line).
- R3: With `spd_hi` = 1, one word is produced for every 4 bits, and the first bit of the group is placed in `word_o[3]` and the last in `word_o[0]`.
- R4: With `spd_hi` = 0, one word is produced for every 2 bits, the first bit is placed in `word_o[1]` and the second in `word_o[0]`, and `word_o[3:2]` is 0.
- R5: `word_vld_o` is high for exactly one cycle per completed word, and `word_o` holds its value until the next word completes.
- R6: While `rx_en` is 0, line changes add no bits and produce no word, any partial word is dropped, and `aligned_o` is 1. The first bit after `rx_en` returns starts a new word.
- R7: `tx_off_o` is 1 whenever `rx_en` is 1 and 0 whenever `rx_en` is 0.
- R8: A change of `spd_hi` drops any partial word, and the group that follows is sized by the new setting.
- R9: `aligned_o` is 0 exactly while one or more bits of an incomplete word are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, four times the word rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable for this port |
| spd_hi | input | 1 | 1 selects 4-bit words, 0 selects 2-bit words |
| line_a | input | 1 | Sampled data line (receive pairing) |
| line_b | input | 1 | Sampled strobe line (receive pairing) |
| word_o | output | 4 | Parallel received word |
| word_vld_o | output | 1 | One-cycle strobe for a completed word |
| aligned_o | output | 1 | High when no partial word is held |
| tx_off_o | output | 1 | Holds this port's line transmitters disabled |

## Verification
The hardest case to reach is a partial word that is cut off by a drop of the receive enable or by a speed change. After the cut, the bits that follow must form a fresh group, and the stale bits must not leak into it. The stimulus reaches this case directly. It sends a number of bits that is not a multiple of the word size, lets the synchronizer settle, and then toggles the enable or the speed select. While receive is disabled it also toggles the lines. Random bit streams with random spacing between bits surround these directed cases, and each produced word is compared against a bench model of the grouping.

// File: rtl/ds_rx_pkg.sv
package ds_rx_pkg;
  localparam int unsigned WORD_W = 4;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned CNT_W  = $clog2(WORD_W);

  // Number of bits per word for the selected speed class.
  function automatic logic [CNT_W:0] bits_per_word(input logic hi);
    return hi ? (CNT_W+1)'(WORD_W) : (CNT_W+1)'(HALF_W);
  endfunction

  // Arrange the shifted-in bits into the output word; the earliest bit
  // lands in the highest position that is used.
  function automatic logic [WORD_W-1:0] place_bits(input logic [WORD_W-1:0] sh,
                                                   input logic hi);
    logic [WORD_W-1:0] w;
    w = '0;
    if (hi) w = sh;
    else    w[HALF_W-1:0] = sh[HALF_W-1:0];
    return w;
  endfunction
endpackage

// File: rtl/ds_rx_sync.sv
module ds_rx_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ds_rx_edge.sv
module ds_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic s_data,
  input  logic s_strb,
  output logic bit_evt,
  output logic bit_val
);
  logic prev_x_q;
  logic cur_x;

  assign cur_x   = s_data ^ s_strb;
  assign bit_evt = cur_x ^ prev_x_q;
  assign bit_val = s_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_x_q <= 1'b0;
    else        prev_x_q <= cur_x;

  // An event only appears when one of the synchronized lines moved.
  p_evt_needs_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |-> (s_data != $past(s_data)) || (s_strb != $past(s_strb)));
endmodule

// File: rtl/ds_rx_pack.sv
module ds_rx_pack
  import ds_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              spd_hi,
  input  logic              bit_evt,
  input  logic              bit_val,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              aligned_o
);
  logic [WORD_W-1:0] sh_q, sh_nxt;
  logic [CNT_W:0]    cnt_q;
  logic              spd_q;
  logic              spd_chg;
  logic              take;
  logic              word_done;

  assign spd_chg   = spd_hi != spd_q;
  assign take      = en && bit_evt && !spd_chg;
  assign sh_nxt    = {sh_q[WORD_W-2:0], bit_val};
  assign word_done = take && (cnt_q + 1'b1 == bits_per_word(spd_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      spd_q      <= 1'b0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      spd_q      <= spd_hi;
      word_vld_o <= 1'b0;
      if (!en || spd_chg) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (word_done) begin
        word_o     <= place_bits(sh_nxt, spd_hi);
        word_vld_o <= 1'b1;
        sh_q       <= '0;
        cnt_q      <= '0;
      end else if (take) begin
        sh_q  <= sh_nxt;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign aligned_o = (cnt_q == '0);

  p_vld_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_o && !spd_q) |-> (word_o[WORD_W-1:HALF_W] == '0));
  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!word_vld_o && aligned_o));
  p_word_ends_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> aligned_o);
  p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld_o |-> $stable(word_o));
endmodule

// File: rtl/ds_rx_deser.sv
module ds_rx_deser
  import ds_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              spd_hi,
  input  logic              line_a,
  input  logic              line_b,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              aligned_o,
  output logic              tx_off_o
);
  logic [1:0] sync_q;
  logic       bit_evt;
  logic       bit_val;

  // Receive pairing: data on line_a, strobe on line_b.
  ds_rx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({line_a, line_b}),
    .q_o  (sync_q)
  );

  ds_rx_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_data (sync_q[1]),
    .s_strb (sync_q[0]),
    .bit_evt(bit_evt),
    .bit_val(bit_val)
  );

  ds_rx_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_en),
    .spd_hi    (spd_hi),
    .bit_evt   (bit_evt),
    .bit_val   (bit_val),
    .word_o    (word_o),
    .word_vld_o(word_vld_o),
    .aligned_o (aligned_o)
  );

  // R7: drivers of this port stay off while it listens.
  assign tx_off_o = rx_en;
endmodule

// File: tb/ds_rx_deser_tb.sv
module ds_rx_deser_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       spd_hi = 1'b1;
  logic       line_a = 1'b0;
  logic       line_b = 1'b0;
  logic [3:0] word_o;
  logic       word_vld_o;
  logic       aligned_o;
  logic       tx_off_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit mon_on = 0;
  bit prev_vld = 0;

  logic [3:0] expq[$];
  logic [3:0] m_sh = '0;
  int         m_n = 0;

  always #10 clk = ~clk;

  ds_rx_deser u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .spd_hi(spd_hi),
    .line_a(line_a), .line_b(line_b), .word_o(word_o),
    .word_vld_o(word_vld_o), .aligned_o(aligned_o), .tx_off_o(tx_off_o)
  );

  function automatic logic [3:0] expect_word(input logic [3:0] sh, input bit hi);
    return hi ? sh : {2'b00, sh[1:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_sh = '0;
    m_n  = 0;
  endtask

  // R2: data follows the bit; strobe toggles when data does not.
  task automatic send_bit(input logic v, input int gap);
    @(negedge clk);
    if (v != line_a) line_a = v;
    else             line_b = ~line_b;
    if (rx_en) begin
      m_sh = {m_sh[2:0], v};
      m_n++;
      if (m_n == (spd_hi ? 4 : 2)) begin
        expq.push_back(expect_word(m_sh, spd_hi));
        model_clear();
      end
    end
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  // Word monitor: R3, R4, R5
  always @(negedge clk) begin
    if (mon_on) begin
      if (word_vld_o) begin
        check(!prev_vld, "R5 single-cycle valid", 1, 0);
        if (expq.size() == 0) begin
          check(0, "R2 unexpected word", word_o, 0);
        end else begin
          logic [3:0] e;
          e = expq.pop_front();
          check(word_o === e, spd_hi ? "R3 word value" : "R4 word value", word_o, e);
        end
      end
      check(tx_off_o === rx_en, "R7 tx off follows rx_en", tx_off_o, rx_en);
      prev_vld = word_vld_o;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1394));
    repeat (3) @(negedge clk);
    check(word_o === 4'h0, "R1 reset word", word_o, 0);
    check(word_vld_o === 1'b0, "R1 reset valid", word_vld_o, 0);
    check(aligned_o === 1'b1, "R1 reset aligned", aligned_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    rx_en = 1'b1;
    mon_on = 1;

    // Directed R3: pattern 1,0,1,1 -> 4'hB, back-to-back bits
    spd_hi = 1'b1;
    settle();
    send_bit(1, 1); send_bit(0, 1); send_bit(1, 1); send_bit(1, 1);
    settle();
    check(expq.size() == 0, "R3 word produced", expq.size(), 0);
    check(word_o === 4'hB, "R3 ordering", word_o, 4'hB);
    // R5 hold
    repeat (3) @(negedge clk);
    check(word_o === 4'hB, "R5 word held", word_o, 4'hB);

    // Directed R4: 0,1 then 1,0
    spd_hi = 1'b0;
    settle();
    model_clear();
    send_bit(0, 1); send_bit(1, 1); send_bit(1, 1); send_bit(0, 1);
    settle();
    check(word_o === 4'h2, "R4 ordering and upper zero", word_o, 4'h2);

    // R9 and R6: partial word cut by enable drop
    spd_hi = 1'b1;
    settle();
    model_clear();
    send_bit(1, 2); send_bit(1, 2); send_bit(0, 2);
    settle();
    check(aligned_o === 1'b0, "R9 partial word held", aligned_o, 0);
    rx_en = 1'b0;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    check(aligned_o === 1'b1, "R6 partial dropped", aligned_o, 1);
    for (int i = 0; i < 6; i++) send_bit(i[0], 2);
    settle();
    check(aligned_o === 1'b1, "R6 lines ignored", aligned_o, 1);
    check(word_o === 4'h2, "R6 no word while off", word_o, 4'h2);
    rx_en = 1'b1;
    @(negedge clk);
    send_bit(0, 1); send_bit(1, 1); send_bit(0, 1); send_bit(1, 1);
    settle();
    check(word_o === 4'h5, "R6 realigned after enable", word_o, 4'h5);

    // R8: speed change drops partial
    spd_hi = 1'b0;
    settle();
    send_bit(1, 2);
    settle();
    check(aligned_o === 1'b0, "R9 one bit held", aligned_o, 0);
    spd_hi = 1'b1;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    check(aligned_o === 1'b1, "R8 speed change drops partial", aligned_o, 1);
    send_bit(0, 1); send_bit(0, 1); send_bit(1, 1); send_bit(1, 1);
    settle();
    check(word_o === 4'h3, "R8 new group size", word_o, 4'h3);

    // Random traffic in both speed classes
    for (int blk = 0; blk < 40; blk++) begin
      spd_hi = blk[0];
      model_clear();
      settle();
      for (int k = 0; k < 24; k++)
        send_bit(1'($urandom_range(0, 1)), int'($urandom_range(1, 4)));
      settle();
      check(aligned_o === 1'b1, "R9 aligned after whole groups", aligned_o, 1);
    end
    settle();
    check(expq.size() == 0, "R2 all expected words seen", expq.size(), 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule